// File: doc/BRIEF.md
# Mesh Dimension-Order Route Unit

This block is the routing stage that sits behind one input port of a switch in a two-dimensional mesh. Packets arrive as a stream of flits, each marked as head, body or tail, under a valid/ready handshake. The head flit carries the remaining distance to its target as two signed offsets, one per axis. The block reads those offsets and chooses one of five output directions: toward smaller x, toward larger x, toward smaller y, toward larger y, or into the attached processor. It then rewrites the head so that the next switch sees the distance left after this hop.

The x offset is always brought to zero before any move along y. A packet therefore never turns from the y axis back onto the x axis. With that turn forbidden, the waits between channels cannot form a cycle, and the mesh cannot deadlock under any traffic. Like a wormhole switch, the block keeps the chosen direction for the body and tail flits that follow a head, and it releases that choice once the tail has been taken downstream. Each flit goes out one cycle after it is accepted, from a registered output stage. That stage holds still while the downstream side stalls.

Top module: `mesh_dor_route`

## Requirements
- R1: A head flit with a negative x offset goes out with port bit 2 set (toward smaller x). A head with a positive x offset goes out with port bit 1 set (toward larger x). In both cases the outgoing x offset is one step closer to zero. The x offset is bits [3:0] and the y offset is bits [7:4], both 4-bit two's complement.
- R2: A head flit with a zero x offset and a positive y offset goes out with port bit 3 set (toward larger y). With a negative y offset it goes out with port bit 4 set (toward smaller y). The outgoing y offset is one step closer to zero, and the x field is unchanged.
- R3: A head flit whose x and y offsets are both zero goes out on port bit 0 (local), with every data bit unchanged.
- R4: Along any path through a 4x4 mesh, every x move comes before every y move. The packet arrives at its target after exactly |dx|+|dy| moves, followed by one local delivery.
- R5: Body and tail flits go out on the port chosen for their head flit, whatever their data bits hold, and their data passes through unchanged.
- R6: The port chosen for a packet is released once its tail flit has been accepted downstream. The next head flit is routed from its own offsets, with no idle cycle between packets.
- R7: While out_valid is high and out_ready is low, out_data, out_port, out_head and out_tail stay unchanged, and in_ready is low.
- R8: out_port is one-hot whenever out_valid is high. The bit meanings are: bit 0 local, bit 1 toward larger x, bit 2 toward smaller x, bit 3 toward larger y, bit 4 toward smaller y.
- R9: During reset out_valid is low and in_ready is high.
- R10: A flit accepted at a clock edge appears on the output side right after that edge (one cycle of latency). Data bits above the offset fields are never altered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Incoming flit is present |
| in_ready | output | 1 | Block can take a flit this cycle |
| in_head | input | 1 | Incoming flit is a head flit |
| in_tail | input | 1 | Incoming flit is a tail flit |
| in_data | input | 16 | Incoming flit data; offsets in [7:0] on head flits |
| out_valid | output | 1 | Outgoing flit is present |
| out_ready | input | 1 | Downstream takes the outgoing flit |
| out_head | output | 1 | Outgoing flit is a head flit |
| out_tail | output | 1 | Outgoing flit is a tail flit |
| out_data | output | 16 | Outgoing flit data with rewritten offsets on heads |
| out_port | output | 5 | One-hot output direction request |

## Verification
The hardest case to reach from the ports is a stalled head flit that has a body flit already waiting behind it. That body flit's data bits look like a negative x offset. The bench drops out_ready right after a head is accepted and keeps presenting the body for several cycles. It then releases the stall and checks two things: the body leaves on the head's port rather than on one decoded from its own bits, and nothing moved while stalled. A second bench feature is a model of a 4x4 mesh. It feeds each rewritten head back in as the next hop for every source and target pair, which checks the order of moves along whole paths.

// File: rtl/mesh_rt_pkg.sv
package mesh_rt_pkg;
  localparam int NPORT = 5;

  // Bit positions of the one-hot direction request
  localparam int P_LOCAL = 0;
  localparam int P_EAST  = 1;
  localparam int P_WEST  = 2;
  localparam int P_NORTH = 3;
  localparam int P_SOUTH = 4;

  typedef logic [NPORT-1:0] port_oh_t;
endpackage

// File: rtl/mesh_dor_decide.sv
module mesh_dor_decide
  import mesh_rt_pkg::*;
#(
  parameter int OFF_W  = 4,
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] hdr_in,
  output port_oh_t          port_oh,
  output logic [DATA_W-1:0] hdr_out
);
  localparam int DX_LO = 0;
  localparam int DY_LO = OFF_W;
  localparam logic [OFF_W-1:0] ONE = OFF_W'(1);

  logic [OFF_W-1:0] dx, dy;
  logic dx_neg, dx_zero, dy_neg, dy_zero;

  assign dx      = hdr_in[DX_LO +: OFF_W];
  assign dy      = hdr_in[DY_LO +: OFF_W];
  assign dx_neg  = dx[OFF_W-1];
  assign dy_neg  = dy[OFF_W-1];
  assign dx_zero = (dx == '0);
  assign dy_zero = (dy == '0);

  always_comb begin
    port_oh = '0;
    hdr_out = hdr_in;
    if (!dx_zero) begin
      // x is reduced first and completely
      if (dx_neg) begin
        port_oh[P_WEST] = 1'b1;
        hdr_out[DX_LO +: OFF_W] = dx + ONE;
      end else begin
        port_oh[P_EAST] = 1'b1;
        hdr_out[DX_LO +: OFF_W] = dx - ONE;
      end
    end else if (!dy_zero) begin
      if (dy_neg) begin
        port_oh[P_SOUTH] = 1'b1;
        hdr_out[DY_LO +: OFF_W] = dy + ONE;
      end else begin
        port_oh[P_NORTH] = 1'b1;
        hdr_out[DY_LO +: OFF_W] = dy - ONE;
      end
    end else begin
      port_oh[P_LOCAL] = 1'b1;
    end
  end
endmodule

// File: rtl/mesh_dor_hold.sv
module mesh_dor_hold
  import mesh_rt_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     set_en,
  input  port_oh_t set_port,
  input  logic     clr_en,
  output port_oh_t hold_port,
  output logic     hold_busy
);
  port_oh_t port_q, port_d;
  logic     busy_q, busy_d;

  always_comb begin
    port_d = port_q;
    busy_d = busy_q;
    // A new head wins over the release of the previous worm
    if (set_en) begin
      port_d = set_port;
      busy_d = 1'b1;
    end else if (clr_en) begin
      port_d = '0;
      busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_q <= '0;
      busy_q <= 1'b0;
    end else if (set_en || clr_en) begin
      port_q <= port_d;
      busy_q <= busy_d;
    end
  end

  assign hold_port = port_q;
  assign hold_busy = busy_q;
endmodule

// File: rtl/mesh_dor_stage.sv
module mesh_dor_stage
  import mesh_rt_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_head,
  input  logic              in_tail,
  input  logic [DATA_W-1:0] in_data,
  input  port_oh_t          in_port,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_head,
  output logic              out_tail,
  output logic [DATA_W-1:0] out_data,
  output port_oh_t          out_port
);
  logic load, valid_d, valid_q;
  logic head_q, tail_q;
  logic [DATA_W-1:0] data_q;
  port_oh_t port_q;

  assign in_ready = !valid_q || out_ready;
  assign load     = in_valid && in_ready;

  always_comb begin
    valid_d = valid_q;
    if (load)           valid_d = 1'b1;
    else if (out_ready) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= 1'b0;
      tail_q <= 1'b0;
      data_q <= '0;
      port_q <= '0;
    end else if (load) begin
      head_q <= in_head;
      tail_q <= in_tail;
      data_q <= in_data;
      port_q <= in_port;
    end
  end

  assign out_valid = valid_q;
  assign out_head  = head_q;
  assign out_tail  = tail_q;
  assign out_data  = data_q;
  assign out_port  = port_q;

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_port)
      && $stable(out_head) && $stable(out_tail));
  // R7
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
endmodule

// File: rtl/mesh_dor_route.sv
module mesh_dor_route
  import mesh_rt_pkg::*;
#(
  parameter int OFF_W  = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_head,
  input  logic              in_tail,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_head,
  output logic              out_tail,
  output logic [DATA_W-1:0] out_data,
  output logic [NPORT-1:0]  out_port
);
  localparam int DX_LO = 0;
  localparam int DY_LO = OFF_W;

  port_oh_t          dec_port, hold_port, sel_port;
  logic [DATA_W-1:0] dec_data, sel_data;
  logic              hold_busy, head_take, tail_leave;

  mesh_dor_decide #(.OFF_W(OFF_W), .DATA_W(DATA_W)) u_decide (
    .hdr_in  (in_data),
    .port_oh (dec_port),
    .hdr_out (dec_data)
  );

  assign head_take  = in_valid && in_ready && in_head;
  assign tail_leave = out_valid && out_ready && out_tail;

  mesh_dor_hold u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_en    (head_take),
    .set_port  (dec_port),
    .clr_en    (tail_leave),
    .hold_port (hold_port),
    .hold_busy (hold_busy)
  );

  assign sel_port = in_head ? dec_port : hold_port;
  assign sel_data = in_head ? dec_data : in_data;

  mesh_dor_stage #(.DATA_W(DATA_W)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_head   (in_head),
    .in_tail   (in_tail),
    .in_data   (sel_data),
    .in_port   (sel_port),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_head  (out_head),
    .out_tail  (out_tail),
    .out_data  (out_data),
    .out_port  (out_port)
  );

  // R8
  port_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $countones(out_port) == 1);
  // R5
  body_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_head |-> out_port == hold_port && hold_busy);
  // R5
  body_has_worm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !in_head |-> hold_busy);
  // R4
  x_before_y_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_head && (out_port[P_NORTH] || out_port[P_SOUTH])
      |-> out_data[DX_LO +: OFF_W] == '0);
  // R3
  local_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    head_take && in_data[DX_LO +: OFF_W] == '0 && in_data[DY_LO +: OFF_W] == '0
      |=> out_port[P_LOCAL] && out_data == $past(in_data));
  // R9
  empty_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);
endmodule

// File: tb/sim_mesh_dor_route.sv
`timescale 1ns/1ps
module sim_mesh_dor_route;
  localparam logic [4:0] PL = 5'b00001;
  localparam logic [4:0] PE = 5'b00010;
  localparam logic [4:0] PW = 5'b00100;
  localparam logic [4:0] PN = 5'b01000;
  localparam logic [4:0] PS = 5'b10000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_head = 1'b0, in_tail = 1'b0, out_ready = 1'b1;
  logic [15:0] in_data = '0;
  logic in_ready, out_valid, out_head, out_tail;
  logic [15:0] out_data;
  logic [4:0]  out_port;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  mesh_dor_route u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_head(in_head), .in_tail(in_tail), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_head(out_head),
    .out_tail(out_tail), .out_data(out_data), .out_port(out_port)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One flit in, observed one cycle later; out_ready assumed high
  task automatic xfer(input logic h, input logic t, input logic [15:0] d,
                      output logic [4:0] p, output logic [15:0] od, output logic ov);
    @(negedge clk);
    in_valid = 1'b1; in_head = h; in_tail = t; in_data = d;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    p = out_port; od = out_data; ov = out_valid;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(out_valid == 1'b0, "R9 out_valid in reset", 32'(out_valid), 0);
    chk(in_ready == 1'b1, "R9 in_ready in reset", 32'(in_ready), 1);
  endtask

  task automatic t_edges();
    logic [4:0] p; logic [15:0] d; logic v;
    xfer(1, 1, 16'hA507, p, d, v);
    chk(v == 1'b1, "R10 latency one cycle", 32'(v), 1);
    chk(p == PE && d == 16'hA506, "R1 dx=+7 east", {p, d}, {PE, 16'hA506});
    xfer(1, 1, 16'h5A38, p, d, v);
    chk(p == PW && d == 16'h5A39, "R1 dx=-8 west", {p, d}, {PW, 16'h5A39});
    xfer(1, 1, 16'hC370, p, d, v);
    chk(p == PN && d == 16'hC360, "R2 dy=+7 north", {p, d}, {PN, 16'hC360});
    xfer(1, 1, 16'h0F80, p, d, v);
    chk(p == PS && d == 16'h0F90, "R2 dy=-8 south", {p, d}, {PS, 16'h0F90});
    xfer(1, 1, 16'hBE00, p, d, v);
    chk(p == PL && d == 16'hBE00, "R3 local unmodified", {p, d}, {PL, 16'hBE00});
  endtask

  task automatic t_worm();
    logic [4:0] p; logic [15:0] d; logic v;
    xfer(1, 0, 16'h0002, p, d, v);
    chk(p == PE && d == 16'h0001, "R1 head east", {p, d}, {PE, 16'h0001});
    xfer(0, 0, 16'h00F8, p, d, v);
    chk(p == PE && d == 16'h00F8, "R5 body follows head", {p, d}, {PE, 16'h00F8});
    xfer(0, 1, 16'h1234, p, d, v);
    chk(p == PE && d == 16'h1234, "R5 tail follows head", {p, d}, {PE, 16'h1234});
    xfer(1, 1, 16'h00F0, p, d, v);
    chk(v && p == PS && d == 16'h0000, "R6 next head rerouted", {p, d}, {PS, 16'h0000});
  endtask

  task automatic t_stall();
    logic [4:0] p0; logic [15:0] d0;
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_head = 1'b1; in_tail = 1'b0; in_data = 16'h3C01;
    @(posedge clk);
    @(negedge clk);
    p0 = out_port; d0 = out_data;
    chk(out_valid && p0 == PE && d0 == 16'h3C00, "R1 stalled head", {p0, d0}, {PE, 16'h3C00});
    in_head = 1'b0; in_tail = 1'b1; in_data = 16'h00F8;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(out_valid && out_head && out_port == p0 && out_data == d0, "R7 held while stalled",
          {out_port, out_data}, {p0, d0});
      chk(in_ready == 1'b0, "R7 in_ready low while stalled", 32'(in_ready), 0);
    end
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid && !out_head && out_tail && out_port == PE && out_data == 16'h00F8,
        "R5 body after stall", {out_port, out_data}, {PE, 16'h00F8});
    @(negedge clk);
  endtask

  task automatic t_grid();
    logic [4:0] p; logic [15:0] d, h; logic v;
    for (int sx = 0; sx < 4; sx++)
      for (int sy = 0; sy < 4; sy++)
        for (int tx = 0; tx < 4; tx++)
          for (int ty = 0; ty < 4; ty++) begin
            int cx = sx, cy = sy, hops = 0;
            bit seen_y = 0, bad_order = 0, off_grid = 0, arrived = 0;
            h = {8'h6D, 4'(ty - sy), 4'(tx - sx)};
            for (int k = 0; k < 10 && !arrived; k++) begin
              xfer(1, 1, h, p, d, v);
              case (p)
                PE: begin cx++; hops++; if (seen_y) bad_order = 1; end
                PW: begin cx--; hops++; if (seen_y) bad_order = 1; end
                PN: begin cy++; hops++; seen_y = 1; end
                PS: begin cy--; hops++; seen_y = 1; end
                PL: arrived = 1;
                default: off_grid = 1;
              endcase
              if (cx < 0 || cx > 3 || cy < 0 || cy > 3) off_grid = 1;
              h = d;
            end
            chk(!bad_order, "R4 x hop after y hop", 32'(bad_order), 0);
            chk(arrived && !off_grid && cx == tx && cy == ty
                && hops == ((tx > sx ? tx - sx : sx - tx) + (ty > sy ? ty - sy : sy - ty))
                && d[15:8] == 8'h6D,
                "R4 arrival", {8'(cx), 8'(cy), 8'(hops), 8'(arrived)}, {8'(tx), 8'(ty), 8'h0, 8'h1});
          end
  endtask

  initial begin
    t_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    t_edges();
    t_worm();
    t_stall();
    t_grid();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule